// File: doc/BRIEF.md
# Hierarchical Statechart Controller with History

This block is a synchronous controller built from a fixed hierarchical statechart that has concurrent regions, a history region and an end state. Every state that carries information owns exactly one flip-flop. No flip-flop is spent on the root or on the two region nodes directly under the concurrent state. All transition enables and next-state values are combinational functions of the flip-flops, the guard inputs and one fed-back event flip-flop. Exactly one set of enabled transitions fires on each clock edge.

The top level holds three states in sequence: `IDLE`, `RUN` and `DONE`. `RUN` is a concurrent composite state with two regions.

- The first region holds `A1`, `A2` and `A3` and remembers its last sub-state.
- The second region holds `B1`, `B2` and the end state `BEND`, and has no history.

When `A2` moves to `A3`, an internal event is raised. It becomes visible one clock later and drives the move from `B2` into `BEND`.

The outputs are the raw flip-flop vector and a derived active vector. A sub-state flip-flop that is set while `RUN` is clear means remembered history, not activity.

Top module: `hsc_top`

## Requirements
- R1: A synchronous active-high `rst` leaves only the `IDLE` flip-flop set and clears every other state flip-flop, history included, and the event flip-flop.
- R2: The bits of `stateActive` follow state-vector order. For a top-level state (bits 0 to 2), the active bit equals its flip-flop. For a sub-state (bits 3 to 8), the active bit is its flip-flop ANDed with the `RUN` flip-flop (bit 1).
- R3: Top-level moves take effect one clock after the guard is seen. `IDLE` goes to `RUN` on `guardIn[0]`. `DONE` goes to `IDLE` on `guardIn[2]`. Exactly one top-level flip-flop is set at any time.
- R4: A guard has no effect unless the source state of its transition is active. In particular, region guards leave the sub-state flip-flops unchanged while `RUN` is inactive.
- R5: `RUN` goes to `DONE` on `guardIn[1]` only while the end state `BEND` is active.
- R6: Default entry works as follows. When `RUN` becomes set, on that same clock each region's default sub-state (`A1`, `B1`) is set, but only if no sibling flip-flop of that region will be set.
- R7: The first region keeps its flip-flop while `RUN` is inactive. Re-entering `RUN` resumes the remembered sub-state instead of `A1`.
- R8: The second region's end state `BEND` is cleared on the clock where `RUN` is cleared. Re-entry then restarts that region at `B1`.
- R9: Firing `A2` to `A3` sets `eventQ` for exactly the next clock. `B2` moves to `BEND` when `B2` is active and `eventQ` is set. Other sub-state moves (one clock latency):
  - `A1` to `A2` on `guardIn[3]`
  - `A2` to `A3` on `guardIn[4]`
  - `A3` to `A1` on `guardIn[5]`
  - `B1` to `B2` on `guardIn[6]`
- R10: State vector bit order is `IDLE`=0, `RUN`=1, `DONE`=2, `A1`=3, `A2`=4, `A3`=5, `B1`=6, `B2`=7, `BEND`=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| guardIn | input | 7 | Guard predicates, one per guarded transition |
| stateQ | output | 9 | Raw state flip-flop values |
| stateActive | output | 9 | Per-state active flag derived along the hierarchy |
| eventQ | output | 1 | Fed-back event flip-flop raised by the `A2` to `A3` move |

## Verification
A guard presented in one cycle changes the flip-flops at the next rising edge, so every flip-flop result is due one clock after its stimulus. The `stateActive` flags follow the flip-flops combinationally in that same cycle. The event-driven move into `BEND` lands two clocks after the `A2` to `A3` guard, one register for the event and one for the state. The bench drives guards on the falling edge and updates its behavioural model at the rising edge. It compares the whole state vector, the active vector and the event bit at the following falling edge, so each comparison lands exactly one register stage after its stimulus.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  localparam int NUM_STATES = 9;
  localparam int NUM_GUARDS = 7;

  // state vector positions
  localparam int ST_IDLE = 0;
  localparam int ST_RUN  = 1;
  localparam int ST_DONE = 2;
  localparam int ST_A1   = 3;
  localparam int ST_A2   = 4;
  localparam int ST_A3   = 5;
  localparam int ST_B1   = 6;
  localparam int ST_B2   = 7;
  localparam int ST_BEND = 8;

  // guard positions
  localparam int GD_GO      = 0;
  localparam int GD_LEAVE   = 1;
  localparam int GD_RESTART = 2;
  localparam int GD_A12     = 3;
  localparam int GD_A23     = 4;
  localparam int GD_A31     = 5;
  localparam int GD_B12     = 6;

  localparam int NO_PARENT = -1;

  // transition strobes handed from control to the state registers
  typedef struct packed {
    logic go;
    logic leave;
    logic restart;
    logic a12;
    logic a23;
    logic a31;
    logic b12;
    logic b2e;
  } fireT;

  // hierarchy: sub-states of both regions hang below RUN
  function automatic int parentOf(input int idx);
    if (idx >= ST_A1 && idx <= ST_BEND) return ST_RUN;
    return NO_PARENT;
  endfunction

  // default chain from the top level downward, taken by reset
  function automatic logic [NUM_STATES-1:0] resetVector();
    logic [NUM_STATES-1:0] v;
    v = '0;
    v[ST_IDLE] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
  import hsc_pkg::*;
(
  input  logic [NUM_STATES-1:0] stateQ,
  input  logic [NUM_GUARDS-1:0] guardIn,
  input  logic                  evQ,
  output logic [NUM_STATES-1:0] stateActive,
  output fireT                  fire
);

  // activity is the AND of flip-flops up the hierarchy path
  for (genvar i = 0; i < NUM_STATES; i++) begin : g_active
    localparam int P = parentOf(i);
    if (P == NO_PARENT) begin : g_top
      assign stateActive[i] = stateQ[i];
    end else begin : g_sub
      assign stateActive[i] = stateQ[i] & stateQ[P];
    end
  end

  // end states that must be active before the composite can be left
  logic runEndsReached;
  assign runEndsReached = stateActive[ST_BEND];

  always_comb begin
    fire         = '0;
    fire.go      = stateActive[ST_IDLE] & guardIn[GD_GO];
    fire.leave   = stateActive[ST_RUN] & runEndsReached & guardIn[GD_LEAVE];
    fire.restart = stateActive[ST_DONE] & guardIn[GD_RESTART];
    fire.a12     = stateActive[ST_A1] & guardIn[GD_A12];
    fire.a23     = stateActive[ST_A2] & guardIn[GD_A23];
    fire.a31     = stateActive[ST_A3] & guardIn[GD_A31];
    fire.b12     = stateActive[ST_B1] & guardIn[GD_B12];
    fire.b2e     = stateActive[ST_B2] & evQ;
  end

endmodule

// File: rtl/hsc_state_regs.sv
module hsc_state_regs
  import hsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  fireT                  fire,
  output logic [NUM_STATES-1:0] stateQ,
  output logic                  evQ
);

  logic [NUM_STATES-1:0] stateNext;
  logic [NUM_STATES-1:0] activateVec;
  logic [NUM_STATES-1:0] inactivateVec;
  logic                  evNext;
  logic                  runPathNext;

  // incoming-transition activation, plus default entry from above
  always_comb begin
    activateVec = '0;
    activateVec[ST_RUN]  = fire.go;
    activateVec[ST_DONE] = fire.leave;
    activateVec[ST_A2]   = fire.a12;
    activateVec[ST_A3]   = fire.a23;
    activateVec[ST_B2]   = fire.b12;
    activateVec[ST_BEND] = fire.b2e;
    activateVec[ST_A1]   = fire.a31;
    activateVec[ST_IDLE] = fire.restart;
  end

  // clearing conditions per state kind
  always_comb begin
    inactivateVec = '0;
    // top automaton: no history, no end state, parent is the root
    inactivateVec[ST_IDLE] = fire.go;
    inactivateVec[ST_RUN]  = fire.leave;
    inactivateVec[ST_DONE] = fire.restart;
    // history region: only own outgoing moves clear
    inactivateVec[ST_A1]   = fire.a12;
    inactivateVec[ST_A2]   = fire.a23;
    inactivateVec[ST_A3]   = fire.a31;
    // region with an end state: ordinary states cleared by own moves
    inactivateVec[ST_B1]   = fire.b12;
    inactivateVec[ST_B2]   = fire.b2e;
    // end state without history: cleared when the parent path drops
    inactivateVec[ST_BEND] = !runPathNext;
  end

  assign runPathNext = activateVec[ST_RUN] | (stateQ[ST_RUN] & !inactivateVec[ST_RUN]);

  always_comb begin
    for (int i = 0; i < NUM_STATES; i++) begin
      stateNext[i] = activateVec[i] | (stateQ[i] & !inactivateVec[i]);
    end
    // default entries: parent path next is set and no sibling will be set
    if (!stateNext[ST_RUN] && !stateNext[ST_DONE]) stateNext[ST_IDLE] = 1'b1;
    if (runPathNext && !stateNext[ST_A2] && !stateNext[ST_A3]) stateNext[ST_A1] = 1'b1;
    if (runPathNext && !stateNext[ST_B2] && !stateNext[ST_BEND]) stateNext[ST_B1] = 1'b1;
  end

  // transition-raised event lives for one clock
  assign evNext = fire.a23;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= resetVector();
      evQ    <= 1'b0;
    end else begin
      stateQ <= stateNext;
      evQ    <= evNext;
    end
  end

endmodule

// File: rtl/hsc_top.sv
module hsc_top
  import hsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_GUARDS-1:0] guardIn,
  output logic [NUM_STATES-1:0] stateQ,
  output logic [NUM_STATES-1:0] stateActive,
  output logic                  eventQ
);

  fireT fire;
  logic evQ;

  hsc_ctrl u_ctrl (
    .stateQ      (stateQ),
    .guardIn     (guardIn),
    .evQ         (evQ),
    .stateActive (stateActive),
    .fire        (fire)
  );

  hsc_state_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .stateQ (stateQ),
    .evQ    (evQ)
  );

  assign eventQ = evQ;

endmodule

// File: rtl/hsc_checker.sv
module hsc_checker
  import hsc_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_STATES-1:0] stateQ,
  input logic [NUM_STATES-1:0] stateActive,
  input logic                  eventQ
);

  assert_top_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(stateQ[ST_DONE:ST_IDLE]) == 1);

  assert_sub_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
    (|stateActive[ST_BEND:ST_A1]) |-> stateActive[ST_RUN]);

  assert_leave_needs_end_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(stateQ[ST_DONE]) |-> $past(stateActive[ST_BEND]));

  assert_default_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stateQ[ST_RUN]) |-> ($countones(stateQ[ST_A3:ST_A1]) == 1 && stateQ[ST_B1]));

  assert_history_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !stateQ[ST_RUN] |=> (stateQ[ST_RUN] || $stable(stateQ[ST_A3:ST_A1])));

  assert_end_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(stateQ[ST_RUN]) |-> !stateQ[ST_BEND]);

  assert_event_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    eventQ |-> stateQ[ST_A3]);

endmodule

bind hsc_top hsc_checker u_hsc_checker (
  .clk         (clk),
  .rst         (rst),
  .stateQ      (stateQ),
  .stateActive (stateActive),
  .eventQ      (eventQ)
);

// File: tb/hsc_top_bench.sv
module hsc_top_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] guardIn;
  logic [8:0] stateQ;
  logic [8:0] stateActive;
  logic       eventQ;

  int    checks   = 0;
  int    failures = 0;
  bit    finished = 0;
  string tag      = "R1";

  // behavioural reference: top 0 idle,1 run,2 done; region positions 0 = none
  int topPos;
  int aPos;
  int bPos;
  bit evRef;

  always #5 clk = ~clk;

  hsc_top u_hsc_top (
    .clk         (clk),
    .rst         (rst),
    .guardIn     (guardIn),
    .stateQ      (stateQ),
    .stateActive (stateActive),
    .eventQ      (eventQ)
  );

  function automatic logic [8:0] expQ();
    logic [8:0] v = '0;
    v[topPos] = 1'b1;
    if (aPos != 0) v[2 + aPos] = 1'b1;
    if (bPos != 0) v[5 + bPos] = 1'b1;
    return v;
  endfunction

  function automatic logic [8:0] expActive();
    logic [8:0] v = expQ();
    if (topPos != 1) v[8:3] = '0;
    return v;
  endfunction

  task automatic check(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(tag, "stateQ", stateQ, expQ());
    check("R2", "stateActive", stateActive, expActive());
    check("R9", "eventQ", {8'b0, eventQ}, {8'b0, evRef});
  endtask

  task automatic modelReset();
    topPos = 0; aPos = 0; bPos = 0; evRef = 0;
  endtask

  task automatic modelStep(input logic [6:0] g);
    bit run = (topPos == 1);
    bit go, leave, restart, a12, a23, a31, b12, b2e;
    go      = topPos == 0 && g[0];
    leave   = run && bPos == 3 && g[1];
    restart = topPos == 2 && g[2];
    a12     = run && aPos == 1 && g[3];
    a23     = run && aPos == 2 && g[4];
    a31     = run && aPos == 3 && g[5];
    b12     = run && bPos == 1 && g[6];
    b2e     = run && bPos == 2 && evRef;
    if (go) topPos = 1;
    else if (leave) topPos = 2;
    else if (restart) topPos = 0;
    if (a12) aPos = 2;
    else if (a23) aPos = 3;
    else if (a31) aPos = 1;
    if (b12) bPos = 2;
    else if (b2e) bPos = 3;
    if (topPos != 1 && bPos == 3) bPos = 0;
    if (topPos == 1 && aPos == 0) aPos = 1;
    if (topPos == 1 && bPos == 0) bPos = 1;
    evRef = a23;
  endtask

  task automatic step(input logic [6:0] g, input bit r);
    guardIn = g;
    rst     = r;
    @(posedge clk);
    if (r) modelReset(); else modelStep(g);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    guardIn = '0;
    rst     = 1'b1;
    modelReset();
    @(negedge clk);
    tag = "R1";
    step('0, 1'b1);
    check("R1", "reset vector", stateQ, 9'b000000001);
    check("R1", "reset event", {8'b0, eventQ}, 9'b0);

    tag = "R4";                       // region guards while RUN is inactive
    step(7'b1111010, 1'b0);
    check("R4", "no effect while idle", stateQ, 9'b000000001);

    tag = "R6";                       // go: default entry into both regions
    step(7'b0000001, 1'b0);
    check("R6", "default entry", stateQ, 9'b001001010);

    tag = "R10";
    step(7'b0001000, 1'b0);           // A1 -> A2
    step(7'b1000000, 1'b0);           // B1 -> B2
    check("R10", "A2 and B2", stateQ, 9'b010010010);

    tag = "R5";                       // leave refused without the end state
    step(7'b0000010, 1'b0);
    check("R5", "leave blocked", stateQ, 9'b010010010);

    tag = "R9";
    step(7'b0010000, 1'b0);           // A2 -> A3, event raised
    check("R9", "event after A2->A3", {8'b0, eventQ}, 9'b1);
    step('0, 1'b0);                   // event drives B2 -> BEND
    check("R9", "BEND reached", stateQ, 9'b100100010);
    check("R9", "event gone", {8'b0, eventQ}, 9'b0);

    tag = "R8";                       // leave now allowed
    step(7'b0000010, 1'b0);
    check("R8", "BEND cleared, A3 kept", stateQ, 9'b000100100);
    check("R2", "history not active", stateActive, 9'b000000100);

    tag = "R4";
    step(7'b1111000, 1'b0);
    check("R4", "region guards while done", stateQ, 9'b000100100);

    tag = "R3";
    step(7'b0000100, 1'b0);           // DONE -> IDLE
    check("R3", "restart", stateQ, 9'b000100001);

    tag = "R7";
    step(7'b0000001, 1'b0);           // re-entry resumes A3, B restarts
    check("R7", "history recall", stateQ, 9'b001100010);

    tag = "R10";
    step(7'b0100000, 1'b0);           // A3 -> A1
    check("R10", "A3 to A1", stateQ, 9'b001001010);

    tag = "R3";
    for (int n = 0; n < 600; n++) begin
      logic [6:0] g = 7'($urandom);
      step(g, ($urandom % 97) == 0);
    end

    tag = "R1";                       // reset clears remembered history
    step(7'b0000001, 1'b0);
    step(7'b0000001, 1'b1);
    check("R1", "reset clears history", stateQ, 9'b000000001);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule